// File: doc/BRIEF.md
# Dual Reloadable Down-Counting Timer

This block holds two independent 32-bit down-counters behind a simple synchronous register port: an address, a write strobe, write data and combinational read data. Each counter takes its decrement ticks from one of two sources. The first is an external reference tick that arrives as a one-cycle enable pulse. The second is the system clock divided by a power of two.

Every counter expires on a tick that finds it at zero. At that point it raises a sticky event flag, which drives a level interrupt line. The auto-reload bit sets what happens next. With auto-reload on, the counter restarts from its reload register, which gives a periodic tick; a reload of all ones makes it a free-running counter. With auto-reload off, the counter stops at zero after a single expiry.

Software acknowledges an event by writing zero to its flag. Bits written as one leave their flags untouched, so one write can acknowledge one timer without disturbing the other.

Top module: `dual_downtimer`

## Requirements
- R1: After reset every register reads zero and both interrupt outputs are low.
- R2: The shared control word at offset 0x00 stores only these fields, and all other bits read back as zero:
  - timer A enable at bit 0 and auto-reload at bit 1;
  - timer B enable at bit 2 and auto-reload at bit 3;
  - reference-tick select at bit 11 (timer A) and bit 12 (timer B);
  - 3-bit prescale field at bits 21:19 (timer A) and bits 24:22 (timer B).
- R3: With its select bit set, an enabled timer counts one tick per `ref_tick` pulse, and the prescale field is ignored. With its select bit clear, it ticks once every 2^N system cycles for a field value N. The first tick comes on the 2^N-th clock edge after the enable is written.
- R4: An enabled timer decrements on each tick. A disabled timer, or one receiving no tick, holds its count.
- R5: A tick that finds the count at zero is an expiry. With auto-reload set, an expiry loads the reload register, so a reload of R gives one expiry every R+1 ticks.
- R6: With the reload register at 0xFFFFFFFF and auto-reload set, the counter wraps from zero to 0xFFFFFFFF and keeps running.
- R7: With auto-reload clear, the counter stays at zero after an expiry and raises its flag only once. It does not expire again until its value register is rewritten.
- R8: A write to a value register (timer A 0x14, timer B 0x1C) loads the count on that clock edge. The write overrides any tick in the same cycle. A read of a value register returns the live count.
- R9: The event register sits at offset 0x04, with timer A's flag at bit 0 and timer B's flag at bit 8. Writing 0 to a flag clears it; writing 1 leaves it unchanged.
- R10: An expiry in the same cycle as a clear of its flag leaves the flag set.
- R11: `irq0` and `irq1` are high exactly while the flags at bit 0 and bit 8 are set.
- R12: The reload registers sit at 0x10 (timer A) and 0x18 (timer B), and they read back the value written. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle reference tick pulse |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` |
| irq0 | output | 1 | Timer A event level |
| irq1 | output | 1 | Timer B event level |

## Verification
The hardest case to reach is an acknowledge that lands on the very edge where the same timer expires again. Both must happen on a single clock edge. The bench loads a small count and enables the timer with a divide-by-one tick, so the expiry edge is known exactly. It then waits the counted number of cycles and issues the clearing write so that its edge coincides with the expiry. The flag must still read as set afterwards. The one-shot stop and the prescaler's first-tick edge are also placed by exact cycle counting rather than by polling.

// File: rtl/dual_downtimer.sv
module dual_downtimer #(
  parameter int ADDR_W = 6,
  parameter int DW     = 32,
  parameter int PRE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq0,
  output logic              irq1
);
  localparam int NT      = 2;
  localparam int PCNT_W  = (1 << PRE_W) - 1;
  localparam int SEL_LSB = 11;
  localparam int DIV_LSB = 19;
  localparam int STAT_STRIDE = 8;
  localparam logic [DW-1:0] CTRL_MASK =
      DW'(32'h0000_000F) | (DW'(2'b11) << SEL_LSB) |
      (((DW'(1) << (NT * PRE_W)) - DW'(1)) << DIV_LSB);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h04);

  logic [DW-1:0] ctrl_q;
  logic [DW-1:0] cnt_q [NT];
  logic [DW-1:0] rld_q [NT];
  logic [NT-1:0][PCNT_W-1:0] pcnt_q, pmask;
  logic [NT-1:0] stat_q, spent_q, tick, expire, val_wr, rld_wr, en, auto, sel;
  logic [NT-1:0][PRE_W-1:0] div;
  logic stat_wr, ctrl_wr;
  logic [DW-1:0] stat_word;

  assign stat_wr = bus_we && (bus_addr == A_STAT);
  assign ctrl_wr = bus_we && (bus_addr == A_CTRL);

  always_comb begin
    stat_word = '0;
    for (int i = 0; i < NT; i++) begin
      en[i]     = ctrl_q[2*i];
      auto[i]   = ctrl_q[2*i+1];
      sel[i]    = ctrl_q[SEL_LSB+i];
      div[i]    = ctrl_q[DIV_LSB+PRE_W*i +: PRE_W];
      for (int k = 0; k < PCNT_W; k++) pmask[i][k] = (k < int'(div[i]));
      tick[i]   = en[i] && (sel[i] ? ref_tick : ((pcnt_q[i] & pmask[i]) == pmask[i]));
      val_wr[i] = bus_we && (bus_addr == ADDR_W'(8'h14 + 8*i));
      rld_wr[i] = bus_we && (bus_addr == ADDR_W'(8'h10 + 8*i));
      expire[i] = tick[i] && (cnt_q[i] == '0) && (auto[i] || !spent_q[i]) && !val_wr[i];
      stat_word[STAT_STRIDE*i] = stat_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      stat_q  <= '0;
      spent_q <= '0;
      pcnt_q  <= '0;
      for (int i = 0; i < NT; i++) begin
        cnt_q[i] <= '0;
        rld_q[i] <= '0;
      end
    end else begin
      if (ctrl_wr) ctrl_q <= bus_wdata & CTRL_MASK;
      for (int i = 0; i < NT; i++) begin
        pcnt_q[i] <= (en[i] && !sel[i]) ? pcnt_q[i] + PCNT_W'(1) : '0;
        if (rld_wr[i]) rld_q[i] <= bus_wdata;
        if (val_wr[i])
          cnt_q[i] <= bus_wdata;
        else if (tick[i] && (auto[i] || !spent_q[i])) begin
          if (cnt_q[i] != '0) cnt_q[i] <= cnt_q[i] - DW'(1);
          else if (auto[i])   cnt_q[i] <= rld_q[i];
        end
        if (val_wr[i] || auto[i]) spent_q[i] <= 1'b0;
        else if (expire[i])       spent_q[i] <= 1'b1;
        stat_q[i] <= expire[i] ||
                     (stat_q[i] && !(stat_wr && !bus_wdata[STAT_STRIDE*i]));
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL) bus_rdata = ctrl_q;
    if (bus_addr == A_STAT) bus_rdata = stat_word;
    for (int i = 0; i < NT; i++) begin
      if (bus_addr == ADDR_W'(8'h10 + 8*i)) bus_rdata = rld_q[i];
      if (bus_addr == ADDR_W'(8'h14 + 8*i)) bus_rdata = cnt_q[i];
    end
  end

  assign irq0 = stat_q[0];
  assign irq1 = stat_q[1];
endmodule

// File: rtl/dual_downtimer_chk.sv
module dual_downtimer_chk #(
  parameter int ADDR_W = 6,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              irq0,
  input logic              irq1,
  input logic [DW-1:0]     cnt0,
  input logic [DW-1:0]     rld0_val,
  input logic              auto0,
  input logic              tick0,
  input logic              spent0
);
  logic vwr0, swr;
  assign vwr0 = bus_we && (bus_addr == ADDR_W'(8'h14));
  assign swr  = bus_we && (bus_addr == ADDR_W'(8'h04));

  p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick0 && cnt0 != '0 && !vwr0 |=> cnt0 == $past(cnt0) - DW'(1));
  p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick0 && !vwr0 |=> $stable(cnt0));
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick0 && cnt0 == '0 && auto0 && !vwr0 |=> cnt0 == $past(rld0_val));
  p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt0 == '0 && !auto0 && !vwr0 |=> cnt0 == '0);
  p_value_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vwr0 |=> cnt0 == $past(bus_wdata));
  p_expire_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick0 && cnt0 == '0 && (auto0 || !spent0) && !vwr0 |=> irq0);
  p_flag0_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq0 && !(swr && !bus_wdata[0]) |=> irq0);
  p_flag1_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq1 && !(swr && !bus_wdata[8]) |=> irq1);
  p_irq_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq0) |-> $past(tick0));
endmodule

bind dual_downtimer dual_downtimer_chk #(.ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq0(irq0), .irq1(irq1),
  .cnt0(cnt_q[0]), .rld0_val(rld_q[0]), .auto0(ctrl_q[1]),
  .tick0(tick[0]), .spent0(spent_q[0]));

// File: tb/dual_downtimer_tb.sv
module dual_downtimer_tb;
  logic clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq0, irq1;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_downtimer u_dut (.clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq0(irq0), .irq1(irq1));

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    ref_tick = 1'b1; @(negedge clk); ref_tick = 1'b0;
  endtask

  task automatic quiet();
    wr(6'h00, 0); wr(6'h04, 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    foreach (d[i]) ;
    for (int a = 0; a < 32; a += 4) begin
      rd(6'(a), d); chk("R1 reset read", d, 0);
    end
    chk("R1 irq0 reset", {31'd0, irq0}, 0);
    chk("R1 irq1 reset", {31'd0, irq1}, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h00, d); chk("R2 control fields", d, 32'h01F8_180F);
    wr(6'h10, 32'h1234_5678); rd(6'h10, d); chk("R12 reload A", d, 32'h1234_5678);
    wr(6'h18, 32'h9ABC_DEF0); rd(6'h18, d); chk("R12 reload B", d, 32'h9ABC_DEF0);
    rd(6'h20, d); chk("R12 unmapped", d, 0);
    quiet();
  endtask

  task automatic t_count();
    logic [31:0] d;
    wr(6'h14, 5); step(3);
    rd(6'h14, d); chk("R4 disabled hold", d, 5);
    wr(6'h00, 32'h1);
    step(1); rd(6'h14, d); chk("R4 decrement", d, 4);
    step(2); rd(6'h14, d); chk("R4 decrement 3", d, 2);
    wr(6'h00, 0);
    step(5); rd(6'h14, d); chk("R4 hold after disable", d, 1);
  endtask

  task automatic t_periodic();
    logic [31:0] d;
    quiet();
    wr(6'h10, 3); wr(6'h14, 3); wr(6'h00, 32'h3);
    step(3);
    rd(6'h04, d); chk("R5 no early expiry", d, 0);
    chk("R11 irq0 low", {31'd0, irq0}, 0);
    step(1);
    rd(6'h04, d); chk("R5 expiry flag bit0", d, 32'h1);
    chk("R11 irq0 high", {31'd0, irq0}, 1);
    rd(6'h14, d); chk("R5 reloaded", d, 3);
    wr(6'h04, 32'hFFFF_FFFE);
    chk("R11 irq0 cleared", {31'd0, irq0}, 0);
    step(2); chk("R5 period R+1 not yet", {31'd0, irq0}, 0);
    step(1); chk("R5 period R+1", {31'd0, irq0}, 1);
    quiet();
  endtask

  task automatic t_prescale();
    wr(6'h14, 2); wr(6'h00, 32'h1 | (32'd2 << 19));
    step(11); chk("R3 divide by 4 early", {31'd0, irq0}, 0);
    step(1);  chk("R3 divide by 4 expiry", {31'd0, irq0}, 1);
    quiet();
    wr(6'h1C, 1); wr(6'h00, 32'h4 | (32'd1 << 22));
    step(3); chk("R3 timer B divide by 2 early", {31'd0, irq1}, 0);
    step(1); chk("R3 timer B divide by 2 expiry", {31'd0, irq1}, 1);
    quiet();
  endtask

  task automatic t_ref_oneshot();
    logic [31:0] d;
    wr(6'h14, 1); wr(6'h00, 32'h1 | 32'h800 | (32'd5 << 19));
    step(10); rd(6'h14, d); chk("R3 no tick without ref pulse", d, 1);
    pulse(); rd(6'h14, d); chk("R3 ref pulse decrements", d, 0);
    chk("R3 no expiry yet", {31'd0, irq0}, 0);
    step(5); pulse(); chk("R3 ref expiry", {31'd0, irq0}, 1);
    rd(6'h14, d); chk("R7 stays at zero", d, 0);
    wr(6'h04, 0);
    pulse(); pulse(); step(2);
    chk("R7 single expiry", {31'd0, irq0}, 0);
    rd(6'h14, d); chk("R7 no wrap", d, 0);
    quiet();
  endtask

  task automatic t_free();
    logic [31:0] d;
    wr(6'h18, 32'hFFFF_FFFF); wr(6'h1C, 1); wr(6'h00, 32'hC);
    step(2); rd(6'h1C, d); chk("R6 wrap to full scale", d, 32'hFFFF_FFFF);
    chk("R6 wrap flags timer B", {31'd0, irq1}, 1);
    step(1); rd(6'h1C, d); chk("R6 keeps running", d, 32'hFFFF_FFFE);
    wr(6'h1C, 100); rd(6'h1C, d); chk("R8 write overrides tick", d, 100);
    step(1); rd(6'h1C, d); chk("R8 live count", d, 99);
    quiet();
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(6'h14, 0); wr(6'h1C, 0); wr(6'h00, 32'h5);
    step(1); wr(6'h00, 0);
    rd(6'h04, d); chk("R9 both flags set", d, 32'h101);
    wr(6'h04, 32'hFFFF_FFFE); rd(6'h04, d); chk("R9 clear only bit0", d, 32'h100);
    wr(6'h04, 32'h1); rd(6'h04, d); chk("R9 clear bit8 ones ignored", d, 0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    quiet();
    wr(6'h14, 2); wr(6'h00, 32'h1);
    step(2);
    wr(6'h04, 0);
    rd(6'h04, d); chk("R10 expiry beats clear", d, 32'h1);
    wr(6'h04, 0);
    rd(6'h04, d); chk("R10 later clear works", d, 0);
    quiet();
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(4);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_ctrl();
    t_count();
    t_periodic();
    t_prescale();
    t_ref_oneshot();
    t_free();
    t_clear();
    t_collide();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule